// File: doc/BRIEF.md
# Multi-Mode Up-Counter Timer with Compare Outputs

This block is a 16-bit up-counter for a small microcontroller peripheral set. A clock-select field picks a power-of-two prescale or stops the counter. A mode field picks where the count turns over: the full counter range, compare value A, or a software-loaded capture register. Up to three compare channels watch the count. On a match, a channel raises its flag and drives its output pin with a selectable action.

Software reaches everything through a byte-wide register port with a 4-bit address. The port covers the control fields, the per-channel pin actions, a write-one-to-clear flag register, the count and the compare and capture values. The two PWM modes buffer compare values and apply them only when the count turns over, so a duty-cycle change never cuts a period short. The active compare values of channels A and B also appear as duty outputs.

Top module: `tmr_core`

## Requirements
- R1: After reset, all registers read zero, the counter is stopped, and `flags`, `cmp_pin`, `cmp_oe`, `duty_a` and `duty_b` are all zero.
- R2: CTRL (address 0) bits [2:0] form the clock select. Code 0 stops counting. Codes 1..7 divide the clock by 1, 8, 64, 256, 1024, 2 and 4 in that order. After a restart, the first increment comes 2^shift clocks after the restarting write.
- R3: CTRL bits [4:3] form the mode, which sets TOP. Mode 0 (normal) and mode 2 (fast PWM) use 2^CNT_W−1. Mode 1 (clear on match) uses compare value A. Mode 3 (PWM) uses the capture register at addresses 11/12.
- R4: On a prescaled tick where the count is at or above TOP, the count becomes 0 and overflow flag bit 0 sets. On any other tick, the count increments by one.
- R5: Writes to address 3 load count bits 7:0, and writes to address 4 load bits 15:8. Counting continues from the written value. A written value at or above TOP wraps to 0 on the next tick. When CNT_W is 8, every high-byte register reads zero.
- R6: Channel i has its compare value at addresses 5+2i (low byte) and 6+2i (high byte). The channel is active only when its value is nonzero and no greater than TOP. An active channel matches on a tick where the count equals its value, and the match sets flag bit 1+i.
- R7: Address 1 bits [2i+1:2i] hold channel i's pin action. 0 disconnects the pin: `cmp_oe` is low and the pin holds its value. 1 toggles the pin on a match, 2 clears it and 3 sets it. `cmp_oe[i]` is high for actions 1 to 3.
- R8: Writing a 1 to a bit of the flag register (address 2) clears that flag. Writing 0 leaves it unchanged.
- R9: The counter and prescaler restart only when a CTRL write changes bits [4:0]. A write that changes only bit 5 (edge select) leaves the count running undisturbed.
- R10: In modes 0 and 1, a compare write takes effect on the same clock edge. In modes 2 and 3, it takes effect at the next wrap, or at a restart. Reads return the written value. `duty_a` and `duty_b` show the active values of channels A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| flags | output | N_CH+1 | Pending flags: bit 0 overflow, bit 1+i channel i |
| cmp_pin | output | N_CH | Compare output pins |
| cmp_oe | output | N_CH | Pin drive enables |
| duty_a | output | 16 | Active compare value of channel A |
| duty_b | output | 16 | Active compare value of channel B |

## Verification
The hardest case to reach is the PWM-mode compare buffer. The written value must stay hidden from the match logic and the duty output for a whole period, and then appear on exactly the wrap edge. The stimulus sets a short TOP through the capture register, writes a new channel B value just after a restart, and samples `duty_b` on the cycle before the wrap and the cycle after it. A second hard case is a count written above TOP in clear-on-match mode. The stimulus writes the count while the counter runs and checks that the next tick wraps it without a false channel match.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    MD_NORMAL  = 2'd0,
    MD_CTC     = 2'd1,
    MD_FAST    = 2'd2,
    MD_PWM_CAP = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    PA_OFF    = 2'd0,
    PA_TOGGLE = 2'd1,
    PA_CLEAR  = 2'd2,
    PA_SET    = 2'd3
  } pin_act_e;

  localparam logic [3:0] A_CTRL     = 4'd0;
  localparam logic [3:0] A_CHACT    = 4'd1;
  localparam logic [3:0] A_FLAGS    = 4'd2;
  localparam logic [3:0] A_CNT_L    = 4'd3;
  localparam logic [3:0] A_CNT_H    = 4'd4;
  localparam int         A_CMP_BASE = 5;
  localparam logic [3:0] A_CAP_L    = 4'd11;
  localparam logic [3:0] A_CAP_H    = 4'd12;

  function automatic logic [3:0] presc_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 4'd0;
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd10;
      3'd6:    return 4'd1;
      3'd7:    return 4'd2;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_presc.sv
`timescale 1ns/1ps
module tmr_presc import tmr_pkg::*; #(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] div_q, div_d, mask;
  logic [PS_W:0]   pow;
  logic            run;

  assign run  = (sel != 3'd0);
  assign pow  = (PS_W+1)'(1) << presc_shift(sel);
  assign mask = PS_W'(pow - (PS_W+1)'(1));
  assign tick = run && ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (restart || !run) div_d = '0;
    else                 div_d = div_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_cmp_ch.sv
`timescale 1ns/1ps
module tmr_cmp_ch import tmr_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] cmp,
  input  pin_act_e      act,
  output logic          hit,
  output logic          pin,
  output logic          oe
);
  logic pin_d;

  assign hit = step && (cmp != '0) && (cmp <= top) && (cnt == cmp);
  assign oe  = (act != PA_OFF);

  always_comb begin
    pin_d = pin;
    if (hit) begin
      case (act)
        PA_TOGGLE: pin_d = ~pin;
        PA_CLEAR:  pin_d = 1'b0;
        PA_SET:    pin_d = 1'b1;
        default:   pin_d = pin;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core import tmr_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 3,
  parameter int PS_W  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [N_CH:0] flags,
  output logic [N_CH-1:0] cmp_pin,
  output logic [N_CH-1:0] cmp_oe,
  output logic [15:0]   duty_a,
  output logic [15:0]   duty_b
);
  localparam logic [DW-1:0] MAX_TOP = DW'((32'd1 << CNT_W) - 32'd1);
  localparam bit HAS_HI = (CNT_W > 8);

  logic [5:0]          ctrl_q, ctrl_d;
  logic [2*N_CH-1:0]   chact_q, chact_d;
  logic [DW-1:0]       cnt_q, cnt_d, cap_q, cap_d, top_val;
  logic [N_CH:0]       flags_q, flags_d, flag_clr;
  logic [N_CH-1:0][DW-1:0] cmp_buf, cmp_act;
  logic [N_CH-1:0]     hit;
  logic                wr_ctrl, restart, presc_tick, step, wrap, cnt_wr, pwm_mode;
  tmr_mode_e           mode;

  assign mode     = tmr_mode_e'(ctrl_q[4:3]);
  assign pwm_mode = (mode == MD_FAST) || (mode == MD_PWM_CAP);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign restart  = wr_ctrl && (bus_wdata[4:0] != ctrl_q[4:0]);
  assign cnt_wr   = bus_wr && ((bus_addr == A_CNT_L) || (HAS_HI && bus_addr == A_CNT_H));

  tmr_presc #(.PS_W(PS_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sel(ctrl_q[2:0]), .tick(presc_tick)
  );

  assign step = presc_tick && !restart;

  always_comb begin
    case (mode)
      MD_CTC:     top_val = cmp_act[0];
      MD_PWM_CAP: top_val = cap_q;
      default:    top_val = MAX_TOP;
    endcase
  end

  assign wrap = step && (cnt_q >= top_val);

  always_comb begin
    ctrl_d  = wr_ctrl ? bus_wdata[5:0] : ctrl_q;
    chact_d = (bus_wr && bus_addr == A_CHACT) ? bus_wdata[2*N_CH-1:0] : chact_q;
    cap_d   = cap_q;
    if (bus_wr && bus_addr == A_CAP_L)           cap_d[7:0]  = bus_wdata;
    if (HAS_HI && bus_wr && bus_addr == A_CAP_H) cap_d[15:8] = bus_wdata;
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (cnt_wr) begin
      if (bus_addr == A_CNT_L) cnt_d[7:0]  = bus_wdata;
      else                     cnt_d[15:8] = bus_wdata;
    end else if (step) begin
      cnt_d = wrap ? '0 : cnt_q + DW'(1);
    end
    flag_clr = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[N_CH:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | {hit, wrap};
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [3:0] A_LO = 4'(A_CMP_BASE + 2*i);
    localparam logic [3:0] A_HI = 4'(A_CMP_BASE + 2*i + 1);
    logic [DW-1:0] buf_q, buf_d, act_q, act_d;

    always_comb begin
      buf_d = buf_q;
      if (bus_wr && bus_addr == A_LO)           buf_d[7:0]  = bus_wdata;
      if (HAS_HI && bus_wr && bus_addr == A_HI) buf_d[15:8] = bus_wdata;
      act_d = (!pwm_mode || restart || wrap) ? buf_d : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        buf_q <= buf_d;
        act_q <= act_d;
      end
    end

    assign cmp_buf[i] = buf_q;
    assign cmp_act[i] = act_q;

    tmr_cmp_ch #(.CW(DW)) i_ch (
      .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt_q), .top(top_val),
      .cmp(act_q), .act(pin_act_e'(chact_q[2*i +: 2])),
      .hit(hit[i]), .pin(cmp_pin[i]), .oe(cmp_oe[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      chact_q <= '0;
      cap_q   <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      chact_q <= chact_d;
      cap_q   <= cap_d;
      cnt_q   <= cnt_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {2'b00, ctrl_q};
      A_CHACT: bus_rdata = 8'(chact_q);
      A_FLAGS: bus_rdata = 8'(flags_q);
      A_CNT_L: bus_rdata = cnt_q[7:0];
      A_CNT_H: bus_rdata = cnt_q[15:8];
      A_CAP_L: bus_rdata = cap_q[7:0];
      A_CAP_H: bus_rdata = cap_q[15:8];
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == 4'(A_CMP_BASE + 2*i))     bus_rdata = cmp_buf[i][7:0];
      if (bus_addr == 4'(A_CMP_BASE + 2*i + 1)) bus_rdata = cmp_buf[i][15:8];
    end
  end

  assign flags  = flags_q;
  assign duty_a = cmp_act[0];
  if (N_CH > 1) begin : g_duty_b
    assign duty_b = cmp_act[1];
  end else begin : g_no_duty_b
    assign duty_b = '0;
  end
endmodule

// File: rtl/tmr_core_chk.sv
`timescale 1ns/1ps
module tmr_core_chk #(
  parameter int N_CH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      sel,
  input logic            step,
  input logic [15:0]     cnt,
  input logic [15:0]     top,
  input logic            cnt_wr,
  input logic            restart,
  input logic [N_CH:0]   flags,
  input logic [N_CH-1:0] hit,
  input logic [N_CH-1:0] pin
);
  // R2
  stopped_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |-> !step);

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr && !restart) |=> $stable(cnt));

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt >= top && !cnt_wr && !restart) |=> (cnt == 16'd0 && flags[0]));

  // R4
  step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt < top && !cnt_wr && !restart) |=> (cnt == $past(cnt) + 16'd1));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R7
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(pin[i]));

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1+i]) |-> $past(hit[i]));
  end
endmodule

bind tmr_core tmr_core_chk #(.N_CH(N_CH)) i_chk (
  .clk(clk), .rst_n(rst_n), .sel(ctrl_q[2:0]), .step(step), .cnt(cnt_q),
  .top(top_val), .cnt_wr(cnt_wr), .restart(restart), .flags(flags_q),
  .hit(hit), .pin(cmp_pin)
);

// File: tb/test_tmr_core.sv
`timescale 1ns/1ps
module test_tmr_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [3:0]  flags;
  logic [2:0]  cmp_pin, cmp_oe;
  logic [15:0] duty_a, duty_b;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tmr_core i_tmr_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
    .cmp_pin(cmp_pin), .cmp_oe(cmp_oe), .duty_a(duty_a), .duty_b(duty_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge; called at a falling edge, returns at the next
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] v);
    bus_addr = a; #0.4; v = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(4'd3, lo); rd8(4'd4, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd8(4'd0, v); chk("R1 ctrl", v, 0);
    rd8(4'd2, v); chk("R1 flag reg", v, 0);
    rd8(4'd3, v); chk("R1 count", v, 0);
    chk("R1 outputs", {flags, cmp_pin, cmp_oe}, 0);
    chk("R1 duty", {duty_a, duty_b}, 0);
  endtask

  task automatic t_count_prescale;
    logic [15:0] c;
    wr(4'd0, 8'h01); wait_cyc(10); rd_cnt(c); chk("R2 div1 count", c, 10);
    wr(4'd0, 8'h03); wait_cyc(63); rd_cnt(c); chk("R2 div64 before", c, 0);
    wait_cyc(1); rd_cnt(c); chk("R2 div64 first step", c, 1);
    wr(4'd0, 8'h06); wait_cyc(1); rd_cnt(c); chk("R2 div2 early", c, 0);
    wait_cyc(4); rd_cnt(c); chk("R2 div2 count", c, 2);
    wr(4'd0, 8'h00); wait_cyc(20); rd_cnt(c); chk("R2 stopped", c, 0);
  endtask

  task automatic t_edge_bit;
    logic [15:0] c;
    logic [7:0] v;
    wr(4'd0, 8'h01); wait_cyc(5);
    wr(4'd0, 8'h21); wait_cyc(4); rd_cnt(c);
    chk("R9 edge write keeps count", c, 10);
    rd8(4'd0, v); chk("R9 ctrl readback", v, 8'h21);
  endtask

  task automatic t_count_write;
    logic [15:0] c;
    wr(4'd3, 8'h34); wr(4'd4, 8'h12); wait_cyc(3); rd_cnt(c);
    chk("R5 count load continues", c, 16'h1237);
  endtask

  task automatic t_ctc_flags;
    logic [15:0] c;
    wr(4'd0, 8'h00); wr(4'd2, 8'hFF);
    wr(4'd5, 8'd5); wr(4'd6, 8'd0);
    wr(4'd7, 8'd7); wr(4'd8, 8'd0);
    chk("R10 immediate duty_a", duty_a, 5);
    wr(4'd0, 8'h09); wait_cyc(5); rd_cnt(c);
    chk("R3 ctc at top", c, 5); chk("R4 no flag yet", flags, 0);
    wait_cyc(1); rd_cnt(c);
    chk("R4 ctc wrap", c, 0);
    chk("R6 flags A+ovf, B above top idle", flags, 4'b0011);
    wr(4'd2, 8'h00); chk("R8 zero write keeps", flags, 4'b0011);
    wr(4'd2, 8'h01); chk("R8 clear ovf only", flags, 4'b0010);
    wr(4'd2, 8'h02); chk("R8 clear A", flags, 4'b0000);
    wr(4'd3, 8'd9); wait_cyc(1); rd_cnt(c);
    chk("R5 above top wraps", c, 0);
    chk("R5 wrap sets only ovf", flags, 4'b0001);
  endtask

  task automatic t_pins;
    wr(4'd0, 8'h00); wr(4'd2, 8'hFF);
    wr(4'd5, 8'd3); wr(4'd7, 8'd3); wr(4'd9, 8'd0);
    wr(4'd1, 8'h3D);
    chk("R7 oe all", cmp_oe, 3'b111);
    wr(4'd0, 8'h01); wait_cyc(3);
    chk("R7 pins before match", cmp_pin, 3'b000);
    wait_cyc(1);
    chk("R7 toggle/set, C zero inactive", cmp_pin, 3'b011);
    chk("R6 match flags", flags, 4'b0110);
    wr(4'd1, 8'h39); wr(4'd3, 8'd2); wait_cyc(2);
    chk("R7 toggle back and clear", cmp_pin, 3'b000);
    wr(4'd1, 8'h00);
    chk("R7 disconnected oe", cmp_oe, 3'b000);
  endtask

  task automatic t_pwm_buffer;
    logic [15:0] c;
    logic [7:0] v;
    wr(4'd0, 8'h00); wr(4'd11, 8'd9); wr(4'd12, 8'd0);
    wr(4'd0, 8'h19);
    chk("R10 restart loads duty_b", duty_b, 3);
    wr(4'd7, 8'd6);
    chk("R10 buffered duty_b held", duty_b, 3);
    rd8(4'd7, v); chk("R10 readback written", v, 6);
    wait_cyc(8); chk("R10 held before wrap", duty_b, 3);
    rd_cnt(c); chk("R3 pwm count at cap top", c, 9);
    wait_cyc(1); chk("R10 applied at wrap", duty_b, 6);
    rd_cnt(c); chk("R3 pwm wrap at capture", c, 0);
    wr(4'd0, 8'h11); wr(4'd2, 8'hFF);
    wr(4'd3, 8'hFE); wr(4'd4, 8'hFF);
    wait_cyc(1); rd_cnt(c); chk("R3 fast pwm max", c, 16'hFFFF);
    chk("R4 no ovf at max", flags[0], 0);
    wait_cyc(1); rd_cnt(c); chk("R3 fast pwm wrap", c, 0);
    chk("R4 ovf at max wrap", flags[0], 1);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_prescale();
    t_edge_bit();
    t_count_write();
    t_ctc_flags();
    t_pins();
    t_pwm_buffer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule